// File: doc/BRIEF.md
# Pulse-Synchronised Double-Bank Sample Player

This block sits between a raw-signal computing pipeline and a DAC driver. It holds two equal sample banks. In each pulse repetition interval, one bank takes the complex samples computed for that interval. The other bank holds the samples of the previous interval and plays them out toward the DAC. Every rising edge of the pulse strobe swaps the two banks. A strobe held high over many cycles still counts as one event.

Playout does not start at the strobe. It starts after a programmable delay that places the scene's range centre inside the interval. The number of samples stored and played per interval is also programmable. Delay and count are captured at each strobe edge, so software can change them at any time without disturbing the interval in progress. A write beyond the programmed count is dropped and raises a flag, which clears at the next strobe. With the default clock of 100 MHz and 512-entry banks, a full bank fits well within a 25 µs interval.

Top module: `pulse_playout_buffer`

## Requirements
- R1: After reset, `out_valid` and `ovf_flag` are 0 and both output sample words are zero.
- R2: Only the low-to-high transition of `prf_in` seen at a clock edge counts as a strobe event. Holding `prf_in` high for several cycles causes exactly one bank swap.
- R3: The samples accepted during one interval are played, in write order starting at bank address 0, during the next interval. Writing never touches the bank being read.
- R4: Let D be the delay captured at a strobe edge E. The first played sample is valid after clock edge E+D+1, and played sample j is valid after edge E+D+1+j, with no gaps between samples.
- R5: Let N be the count captured at a strobe edge. Exactly N samples are played in that interval, after which `out_valid` returns to 0.
- R6: Whenever `out_valid` is 0, `out_i` and `out_q` are both zero.
- R7: A write is dropped, and `ovf_flag` goes to 1, when it arrives while N samples have already been accepted in the current interval. The flag stays set until the next strobe edge clears it.
- R8: The interval that begins at the first strobe edge after reset plays nothing.
- R9: A strobe edge that arrives while playout is still running ends that playout. `out_valid` is 0 after that edge, and the new interval's timing takes over.
- R10: `delay_cfg` and `count_cfg` are sampled only at a strobe edge. Changing them later in the interval affects neither the current playout nor the current write limit.
- R11: A write presented in the same cycle as a strobe edge belongs to the new interval and is stored at address 0 of the new write bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prf_in | input | 1 | Pulse repetition strobe, level input, rising edge used |
| wr_valid | input | 1 | Write strobe for one computed sample |
| wr_i | input | SMP_W | In-phase part of the written sample |
| wr_q | input | SMP_W | Quadrature part of the written sample |
| delay_cfg | input | DLY_W | Range-centre delay in clock cycles after the strobe edge |
| count_cfg | input | CNT_W | Samples stored and played per interval (0 to 2**ADDR_W) |
| out_valid | output | 1 | Played sample is valid |
| out_i | output | SMP_W | In-phase part of the played sample, zero when idle |
| out_q | output | SMP_W | Quadrature part of the played sample, zero when idle |
| ovf_flag | output | 1 | A write was dropped in this interval |

## Verification
The embedded properties check the following on every cycle:
- A held strobe never swaps the banks.
- A write and a read in the same cycle always use different banks.
- The read address stays below the captured count.
- No sample appears while the delay is still counting.
- The overflow flag rises only on a write and is cleared by a strobe edge that brings no write.

Some behaviour depends on the data itself, so only the bench scenarios can show it:
- Data written in one interval comes back in the next, in write order, at the exact delayed cycle.
- Dropped writes never reach the output.
- Playout is cut short by an early strobe.
- Settings changed after the strobe edge are ignored.

// File: rtl/ppb_pkg.sv
// Shared definitions for the double-bank sample player.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package ppb_pkg;

    // Playout sequencer phases within one pulse interval.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no playout pending in this interval
        PH_WAIT = 2'd1,   // counting the range-centre delay
        PH_PLAY = 2'd2    // streaming samples out of the read bank
    } play_phase_t;

endpackage

// File: rtl/ppb_prf_ctrl.sv
// Strobe front end: detects the rising edge of the pulse strobe, owns the
// bank-role bit, captures delay and count at each edge, and remembers
// whether a previous interval exists (so the first interval plays nothing).
// Assumes: prf_in is already synchronous to clk.
module ppb_prf_ctrl #(
    parameter int DLY_W = 12,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prf_in,
    input  logic [DLY_W-1:0] delay_cfg,
    input  logic [CNT_W-1:0] count_cfg,
    output logic             prf_rise,
    output logic             arm,
    output logic             wr_bank_eff,
    output logic             rd_bank,
    output logic [DLY_W-1:0] dly_lat,
    output logic [CNT_W-1:0] cnt_lat,
    output logic [CNT_W-1:0] cnt_eff
);

    logic prf_q;
    logic bank_q;
    logic primed_q;

    // Edge detect: a rise is a high sample after a low one.
    assign prf_rise    = prf_in & ~prf_q;
    // Arm playout only if an earlier interval has filled a bank.
    assign arm         = prf_rise & primed_q;
    // The write bank in effect this cycle, counting a swap happening now.
    assign wr_bank_eff = prf_rise ? ~bank_q : bank_q;
    // Read bank is the opposite of the registered write bank.
    assign rd_bank     = ~bank_q;
    // Write limit in effect this cycle, counting a capture happening now.
    assign cnt_eff     = prf_rise ? count_cfg : cnt_lat;

    // Register the strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prf_q <= 1'b0;
        else        prf_q <= prf_in;
    end

    // Swap bank roles and capture settings on every strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q   <= 1'b0;
            primed_q <= 1'b0;
            dly_lat  <= '0;
            cnt_lat  <= '0;
        end else if (prf_rise) begin
            bank_q   <= ~bank_q;
            primed_q <= 1'b1;
            dly_lat  <= delay_cfg;
            cnt_lat  <= count_cfg;
        end
    end

    AST_HELD_PRF_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (prf_in && prf_q) |=> $stable(bank_q)); // R2

endmodule

// File: rtl/ppb_writer.sv
// Write-side address generator: numbers accepted samples from address 0 in
// each interval, drops writes past the captured count and flags them.
// Assumes: cnt_eff already reflects a capture happening in the same cycle.
module ppb_writer #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prf_rise,
    input  logic              wr_valid,
    input  logic [CNT_W-1:0]  cnt_eff,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              overflow
);

    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] slot;
    logic             accept;

    // A strobe edge restarts numbering; a write in that cycle takes slot 0.
    assign slot   = prf_rise ? '0 : wr_cnt;
    assign accept = wr_valid && (slot < cnt_eff);
    assign we     = accept;
    assign waddr  = slot[ADDR_W-1:0];

    // Count accepted writes and keep the per-interval overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt   <= '0;
            overflow <= 1'b0;
        end else if (prf_rise) begin
            wr_cnt   <= accept ? CNT_W'(1) : '0;
            overflow <= wr_valid && !accept;
        end else begin
            if (accept)               wr_cnt   <= wr_cnt + CNT_W'(1);
            if (wr_valid && !accept)  overflow <= 1'b1;
        end
    end

    AST_OVF_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(wr_valid)); // R7
    AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (prf_rise && !wr_valid) |=> !overflow); // R7

endmodule

// File: rtl/ppb_bank.sv
// One sample bank: a single write port and a registered read port.
// Assumes: reads and writes of one bank never coincide (ping-pong use).
module ppb_bank #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a sample when the write port is enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch a sample into the output register when the read port is enabled.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/ppb_reader.sv
// Playout sequencer: after an armed strobe edge it waits the captured delay,
// then reads the captured number of samples from address 0 upward, one per
// cycle. A new strobe edge always restarts it.
// Assumes: dly_lat/cnt_lat are captured on the same edge that reloads it.
module ppb_reader
    import ppb_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 10,
    parameter int DLY_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prf_rise,
    input  logic              arm,
    input  logic [DLY_W-1:0]  dly_lat,
    input  logic [CNT_W-1:0]  cnt_lat,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_valid
);

    play_phase_t      phase;
    logic [DLY_W-1:0] dly_cnt;
    logic [CNT_W-1:0] rd_ptr;
    logic             delay_done;
    logic             fire;
    logic             play;

    assign delay_done = (dly_cnt == dly_lat);
    // First read issues on the cycle the delay expires.
    assign fire    = !prf_rise && (phase == PH_WAIT) && delay_done && (cnt_lat != '0);
    assign play    = !prf_rise && (phase == PH_PLAY);
    assign rd_en   = fire || play;
    assign rd_addr = play ? rd_ptr[ADDR_W-1:0] : '0;

    // Advance the delay counter and the read pointer through the interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            dly_cnt <= '0;
            rd_ptr  <= '0;
        end else if (prf_rise) begin
            phase   <= arm ? PH_WAIT : PH_IDLE;
            dly_cnt <= '0;
            rd_ptr  <= '0;
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (delay_done) begin
                        rd_ptr <= CNT_W'(1);
                        phase  <= (cnt_lat > CNT_W'(1)) ? PH_PLAY : PH_IDLE;
                    end else begin
                        dly_cnt <= dly_cnt + DLY_W'(1);
                    end
                end
                PH_PLAY: begin
                    rd_ptr <= rd_ptr + CNT_W'(1);
                    if (rd_ptr == cnt_lat - CNT_W'(1)) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Valid follows the bank's registered read by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= rd_en;
    end

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (CNT_W'(rd_addr) < cnt_lat)); // R5
    AST_QUIET_DURING_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && !delay_done) |=> !out_valid); // R4

endmodule

// File: rtl/pulse_playout_buffer.sv
// Top level: two sample banks in ping-pong use. The bank written in one
// pulse interval is played out in the next, starting at a captured delay
// after the strobe edge. Output words are forced to zero outside playout.
// Assumes: prf_in synchronous to clk; count_cfg <= 2**ADDR_W.
module pulse_playout_buffer #(
    parameter int SMP_W  = 16,
    parameter int ADDR_W = 9,
    parameter int DLY_W  = 12,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prf_in,
    input  logic             wr_valid,
    input  logic [SMP_W-1:0] wr_i,
    input  logic [SMP_W-1:0] wr_q,
    input  logic [DLY_W-1:0] delay_cfg,
    input  logic [CNT_W-1:0] count_cfg,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_i,
    output logic [SMP_W-1:0] out_q,
    output logic             ovf_flag
);

    localparam int DATA_W = 2 * SMP_W;

    logic              prf_rise;
    logic              arm;
    logic              wr_bank_eff;
    logic              rd_bank;
    logic [DLY_W-1:0]  dly_lat;
    logic [CNT_W-1:0]  cnt_lat;
    logic [CNT_W-1:0]  cnt_eff;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_sel_q;
    logic [DATA_W-1:0] bank_rdata [2];
    logic [DATA_W-1:0] play_word;

    ppb_prf_ctrl #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .prf_in      (prf_in),
        .delay_cfg   (delay_cfg),
        .count_cfg   (count_cfg),
        .prf_rise    (prf_rise),
        .arm         (arm),
        .wr_bank_eff (wr_bank_eff),
        .rd_bank     (rd_bank),
        .dly_lat     (dly_lat),
        .cnt_lat     (cnt_lat),
        .cnt_eff     (cnt_eff)
    );

    ppb_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .prf_rise (prf_rise),
        .wr_valid (wr_valid),
        .cnt_eff  (cnt_eff),
        .we       (we),
        .waddr    (waddr),
        .overflow (ovf_flag)
    );

    ppb_reader #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .prf_rise  (prf_rise),
        .arm       (arm),
        .dly_lat   (dly_lat),
        .cnt_lat   (cnt_lat),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .out_valid (out_valid)
    );

    // Two identical banks; each is enabled only when it holds the given role.
    for (genvar g = 0; g < 2; g++) begin : g_bank
        ppb_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .we    (we && (wr_bank_eff == (g != 0))),
            .waddr (waddr),
            .wdata ({wr_i, wr_q}),
            .re    (rd_en && (rd_bank == (g != 0))),
            .raddr (rd_addr),
            .rdata (bank_rdata[g])
        );
    end

    // Remember which bank fed the output register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_sel_q <= 1'b0;
        else if (rd_en) rd_sel_q <= rd_bank;
    end

    // Select the active bank and force zero outside playout.
    assign play_word = out_valid ? bank_rdata[rd_sel_q] : '0;
    assign out_i     = play_word[DATA_W-1:SMP_W];
    assign out_q     = play_word[SMP_W-1:0];

    AST_BANKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && we) |-> (rd_bank != wr_bank_eff)); // R3

endmodule

// File: tb/test_pulse_playout_buffer.sv
module test_pulse_playout_buffer;

    localparam int SMP_W  = 16;
    localparam int ADDR_W = 9;
    localparam int DLY_W  = 12;
    localparam int CNT_W  = ADDR_W + 1;

    typedef struct {
        int              cyc;
        logic [SMP_W-1:0] i;
        logic [SMP_W-1:0] q;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prf_in = 1'b0;
    logic             wr_valid = 1'b0;
    logic [SMP_W-1:0] wr_i = '0;
    logic [SMP_W-1:0] wr_q = '0;
    logic [DLY_W-1:0] delay_cfg = '0;
    logic [CNT_W-1:0] count_cfg = '0;
    logic             out_valid;
    logic [SMP_W-1:0] out_i;
    logic [SMP_W-1:0] out_q;
    logic             ovf_flag;

    int   tests = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    int   iv_idx = 0;
    exp_t sb[$];
    logic [SMP_W-1:0] prev_i [512];
    logic [SMP_W-1:0] cur_i  [512];

    pulse_playout_buffer #(.SMP_W(SMP_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) i_pulse_playout_buffer (
        .clk(clk), .rst_n(rst_n), .prf_in(prf_in), .wr_valid(wr_valid),
        .wr_i(wr_i), .wr_q(wr_q), .delay_cfg(delay_cfg), .count_cfg(count_cfg),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    // Monitor: compare scoreboard items due this cycle, else expect idle zero.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() > 0 && sb[0].cyc == cyc) begin
                tests++;
                if (!(out_valid === 1'b1 && out_i === sb[0].i && out_q === sb[0].q)) begin
                    fails++;
                    $display("FAIL R3/R4: cycle %0d got v=%b %h/%h exp v=1 %h/%h",
                             cyc, out_valid, out_i, out_q, sb[0].i, sb[0].q);
                end
                void'(sb.pop_front());
            end else if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
                // R5 R6 R8 R9: nothing may appear outside expected playout
                tests++;
                fails++;
                $display("FAIL R6: cycle %0d got v=%b %h/%h exp v=0 0000/0000",
                         cyc, out_valid, out_i, out_q);
            end
        end
    end

    // Driver: one pulse interval of len cycles starting with a strobe edge.
    task automatic interval(input int d, input int n, input int nwr,
                            input int hold, input int len, input int base);
        int c;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (t == 0) begin
                c = cyc;
                delay_cfg = DLY_W'(d);
                count_cfg = CNT_W'(n);
                // R9: playout of the previous interval ends at edge c+1
                while (sb.size() > 0 && sb[sb.size()-1].cyc >= c + 1) void'(sb.pop_back());
                // R3 R4 R5 R8: previous interval plays now, if one existed
                if (iv_idx > 0)
                    for (int j = 0; j < n; j++)
                        sb.push_back('{c + 2 + d + j, prev_i[j], ~prev_i[j]});
            end
            if (t == 1) begin
                // R10: later changes must not matter
                delay_cfg = DLY_W'(100);
                count_cfg = CNT_W'(3);
            end
            prf_in   = (t < hold);
            wr_valid = (t < nwr);
            wr_i     = SMP_W'(base + t);
            wr_q     = ~SMP_W'(base + t);
            // R11: write at t==0 lands at address 0 of the new bank
            if (t < nwr && t < n) cur_i[t] = SMP_W'(base + t);
            if (t == nwr + 1) begin
                tests++;
                if (ovf_flag !== (nwr > n)) begin
                    fails++;
                    $display("FAIL R7: interval %0d ovf got %b exp %b", iv_idx, ovf_flag, (nwr > n));
                end
            end
        end
        for (int j = 0; j < 512; j++) prev_i[j] = cur_i[j];
        iv_idx++;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        tests++;
        if (out_valid !== 1'b0) begin fails++; $display("FAIL R1: out_valid got %b exp 0", out_valid); end
        tests++;
        if (out_i !== '0 || out_q !== '0) begin fails++; $display("FAIL R1: out got %h/%h exp 0/0", out_i, out_q); end
        tests++;
        if (ovf_flag !== 1'b0) begin fails++; $display("FAIL R1: ovf got %b exp 0", ovf_flag); end
        mon_on = 1'b1;

        interval(5, 16, 16, 1, 30, 16'h1000);   // R8: nothing plays
        interval(0, 16, 16, 5, 40, 16'h2000);   // R2: strobe held 5 cycles, zero delay
        interval(20, 16, 20, 1, 50, 16'h3000);  // R7: four writes dropped
        interval(3, 16, 16, 1, 40, 16'h4000);   // plays first 16 of previous
        interval(40, 16, 16, 1, 48, 16'h5000);  // R9: cut short by next strobe
        interval(7, 12, 40, 1, 60, 16'h6000);   // R5: shorter count, overflow again
        interval(1, 12, 0, 1, 40, 16'h7000);    // R7: flag cleared, plays 12
        prf_in = 1'b0;
        wr_valid = 1'b0;
        repeat (20) @(negedge clk);
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R5: %0d expected samples never appeared exp 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not end, got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule